// File: doc/BRIEF.md
# Oversampled serial line receiver

This block turns an asynchronous serial input into parallel words. A programmable divider produces a sample tick. Each bit period lasts a fixed number of ticks. A state machine locks onto the falling edge of a start bit and confirms the start bit at mid-bit. It then takes each data bit, least significant first, at the middle sample of its period. An optional parity bit and one or two stop bits follow. When the last stop bit is judged, the block reports a completed word for a receive FIFO that sits outside it, together with one-cycle status pulses for framing error, parity error, overrun and a match against a programmed value.

Two side monitors share the sample tick. One reports a line break when the line has stayed low for thirteen bit times. The other reports an idle timeout when no new word has completed within a programmed number of bit times. Before any of this logic sees the line, it passes through a two-flop synchronizer and an optional filter that ignores runs shorter than the filter window.

The state machine has seven states. IDLE goes to START when a tick sees the line low. START goes back to IDLE if the line is high at mid-bit (false start), and goes to DATA at the end of the bit. DATA goes to PARITY after the last data bit when parity is on, and to STOP1 otherwise. PARITY goes to STOP1 at the end of the bit. STOP1 goes to STOP2 at the end of the bit when two stop bits are selected. With one stop bit, STOP1 completes the word at mid-bit. STOP2 always completes the word at mid-bit. A completion goes to IDLE if the line is high and to RECOVER if it is low. RECOVER goes to IDLE once the line is high. Dropping `rx_enable` forces IDLE from any state.

Top module: `serial_rx_engine`

## Requirements
- R1: After reset, and while the line stays high, every output is 0 and no word is reported.
- R2: A frame is a low start bit, `word_len` data bits sent least significant bit first, an optional parity bit, and one stop bit, or two when `two_stop`=1. `word_len` values below 5 act as 5 and values above MAXW act as MAXW. On completion, `word_data` holds the word with every bit above the word length equal to 0.
- R3: One sample tick occurs every `prescale`+1 clock cycles, and a bit lasts OVS ticks. A start bit that is no longer low at its middle sample (tick OVS/2) is a false start: no word is reported and the receiver looks for the next falling edge.
- R4: `parity_mode` selects the parity bit: 3'b001 odd (data plus parity bit has an odd count of ones), 3'b010 even, 3'b100 parity bit always 0, 3'b101 parity bit always 1. Any other code means no parity bit. `err_parity` pulses in the completion cycle when the received parity bit differs from the expected one.
- R5: `err_frame` pulses in the completion cycle when any stop bit is low at its middle sample. After such a frame, no new start is sought until the line has been high.
- R6: When `fifo_full` is 1 in the cycle the last stop bit is judged, `err_overrun` pulses instead of `word_valid`. Otherwise `word_valid` pulses.
- R7: `match_hit` pulses in the completion cycle, whether the word was written or overran, when the zero-filled word equals `match_value`.
- R8: `line_break` pulses once when the line has been low for 13 consecutive bit times (13·OVS ticks). It does not pulse again until the line has been high. Shorter low runs produce no pulse.
- R9: With `idle_bits`=N>0, `idle_timeout` pulses once when N·OVS ticks pass in IDLE after a completion with no new frame starting. N=0 disables the timer and drops any pending count.
- R10: With `filter_en`=1, the line seen by the receiver changes only after GF_LEN consecutive equal synchronized samples, so shorter glitches do not corrupt a frame.
- R11: While `rx_enable` is 0, the receiver stays in IDLE and no output pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_enable | input | 1 | Receiver enable; 0 holds IDLE and silences outputs |
| filter_en | input | 1 | Selects the filtered line instead of the synchronized line |
| prescale | input | PRE_W | Clock cycles per sample tick, minus one |
| word_len | input | 4 | Data bits per frame, clamped to 5..MAXW |
| two_stop | input | 1 | 1 selects two stop bits |
| parity_mode | input | 3 | Parity selection code (see R4) |
| idle_bits | input | TO_W | Idle timeout in bit times; 0 disables |
| match_value | input | MAXW | Value compared with each received word |
| fifo_full | input | 1 | Receive FIFO full status |
| rxd | input | 1 | Asynchronous serial input |
| word_valid | output | 1 | One-cycle pulse: word to be written to the FIFO |
| word_data | output | MAXW | Received word, zero-filled above the word length |
| err_frame | output | 1 | Stop bit found low |
| err_parity | output | 1 | Parity mismatch |
| err_overrun | output | 1 | Word completed while the FIFO was full |
| match_hit | output | 1 | Word equals `match_value` |
| line_break | output | 1 | Thirteen bit times of low line |
| idle_timeout | output | 1 | Idle time limit reached after the last word |

## Verification
The bench builds the block with OVS=8, MAXW=9 and GF_LEN=4, and runs `prescale` at 1 (16-clock bits) and briefly at 3 (32-clock bits). Short bits make the 13-bit break threshold and multi-bit idle timeouts reachable in a few hundred cycles. A 9-bit maximum word lets the upper clamp of the word length and zero fill both be exercised. A 4-stage filter window means 2-clock glitches placed inside every bit must be removed for the frame to decode correctly. An 11-bit low run, set against a 16-bit one, pins down the break boundary.

// File: rtl/srx_pkg.sv
package srx_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PARITY,
        S_STOP1,
        S_STOP2,
        S_RECOVER
    } srx_state_t;

    localparam logic [2:0] PAR_ODD  = 3'b001;
    localparam logic [2:0] PAR_EVEN = 3'b010;
    localparam logic [2:0] PAR_LOW  = 3'b100;
    localparam logic [2:0] PAR_HIGH = 3'b101;

    function automatic logic parity_present(input logic [2:0] mode);
        return (mode == PAR_ODD) || (mode == PAR_EVEN) ||
               (mode == PAR_LOW) || (mode == PAR_HIGH);
    endfunction

endpackage

// File: rtl/srx_sample_tick.sv
module srx_sample_tick #(
    parameter int PRE_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PRE_W-1:0] prescale,
    output logic             tick
);
    logic [PRE_W-1:0] div_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt <= '0;
            tick    <= 1'b0;
        end else if (!run) begin
            div_cnt <= '0;
            tick    <= 1'b0;
        end else if (div_cnt >= prescale) begin
            div_cnt <= '0;
            tick    <= 1'b1;
        end else begin
            div_cnt <= div_cnt + 1'b1;
            tick    <= 1'b0;
        end
    end
endmodule

// File: rtl/srx_line_cond.sv
module srx_line_cond #(
    parameter int GF_LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rxd,
    input  logic filter_en,
    output logic line
);
    logic sync_a, sync_b, filt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_a <= 1'b1;
            sync_b <= 1'b1;
        end else begin
            sync_a <= rxd;
            sync_b <= sync_a;
        end
    end

    generate
        if (GF_LEN >= 2) begin : g_window
            logic [GF_LEN-1:0] hist;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    hist <= '1;
                    filt <= 1'b1;
                end else begin
                    hist <= {hist[GF_LEN-2:0], sync_b};
                    if (&hist)
                        filt <= 1'b1;
                    else if (~|hist)
                        filt <= 1'b0;
                end
            end
        end else begin : g_bypass
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) filt <= 1'b1;
                else        filt <= sync_b;
            end
        end
    endgenerate

    assign line = filter_en ? filt : sync_b;
endmodule

// File: rtl/srx_break_det.sv
module srx_break_det #(
    parameter int OVS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    input  logic line,
    output logic brk_pulse
);
    localparam int BRK_LIM = 13 * OVS;
    localparam int BW      = $clog2(BRK_LIM + 1);

    logic [BW-1:0] low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt   <= '0;
            brk_pulse <= 1'b0;
        end else if (!run) begin
            low_cnt   <= '0;
            brk_pulse <= 1'b0;
        end else begin
            brk_pulse <= tick && !line && (low_cnt == BW'(BRK_LIM - 1));
            if (tick) begin
                if (line)
                    low_cnt <= '0;
                else if (low_cnt != BW'(BRK_LIM))
                    low_cnt <= low_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/srx_idle_timer.sv
module srx_idle_timer #(
    parameter int OVS  = 8,
    parameter int TO_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            tick,
    input  logic            idle,
    input  logic            arm,
    input  logic [TO_W-1:0] limit_bits,
    output logic            to_pulse
);
    localparam int LIM_W = TO_W + $clog2(OVS + 1);

    logic [LIM_W-1:0] limit, idle_cnt;
    logic             armed;

    assign limit = LIM_W'(limit_bits) * LIM_W'(OVS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed    <= 1'b0;
            idle_cnt <= '0;
            to_pulse <= 1'b0;
        end else if (!run || limit_bits == '0) begin
            armed    <= 1'b0;
            idle_cnt <= '0;
            to_pulse <= 1'b0;
        end else begin
            to_pulse <= 1'b0;
            if (arm) begin
                armed    <= 1'b1;
                idle_cnt <= '0;
            end else if (!idle) begin
                idle_cnt <= '0;
            end else if (armed && tick) begin
                if (idle_cnt + LIM_W'(1) == limit) begin
                    to_pulse <= 1'b1;
                    armed    <= 1'b0;
                    idle_cnt <= '0;
                end else begin
                    idle_cnt <= idle_cnt + LIM_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/serial_rx_engine.sv
module serial_rx_engine
    import srx_pkg::*;
#(
    parameter int OVS    = 8,
    parameter int MAXW   = 9,
    parameter int GF_LEN = 8,
    parameter int PRE_W  = 16,
    parameter int TO_W   = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_enable,
    input  logic             filter_en,
    input  logic [PRE_W-1:0] prescale,
    input  logic [3:0]       word_len,
    input  logic             two_stop,
    input  logic [2:0]       parity_mode,
    input  logic [TO_W-1:0]  idle_bits,
    input  logic [MAXW-1:0]  match_value,
    input  logic             fifo_full,
    input  logic             rxd,
    output logic             word_valid,
    output logic [MAXW-1:0]  word_data,
    output logic             err_frame,
    output logic             err_parity,
    output logic             err_overrun,
    output logic             match_hit,
    output logic             line_break,
    output logic             idle_timeout
);
    localparam int SC_W  = $clog2(OVS);
    localparam int IDX_W = $clog2(MAXW);
    localparam logic [SC_W-1:0] MID  = SC_W'(OVS / 2);
    localparam logic [SC_W-1:0] LAST = SC_W'(OVS - 1);

    srx_state_t        state, nxt;
    logic              tick, line;
    logic [SC_W-1:0]   samp_cnt;
    logic [IDX_W-1:0]  bit_idx, last_idx;
    logic [MAXW-1:0]   shreg;
    logic              par_bit, stop_bad, par_on, exp_par;
    logic              at_mid, at_last, done;

    srx_sample_tick #(.PRE_W(PRE_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(rx_enable), .prescale(prescale), .tick(tick)
    );

    srx_line_cond #(.GF_LEN(GF_LEN)) u_line (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .filter_en(filter_en), .line(line)
    );

    srx_break_det #(.OVS(OVS)) u_brk (
        .clk(clk), .rst_n(rst_n), .run(rx_enable), .tick(tick), .line(line),
        .brk_pulse(line_break)
    );

    srx_idle_timer #(.OVS(OVS), .TO_W(TO_W)) u_idle (
        .clk(clk), .rst_n(rst_n), .run(rx_enable), .tick(tick),
        .idle(state == S_IDLE), .arm(done), .limit_bits(idle_bits),
        .to_pulse(idle_timeout)
    );

    // Index of the final data bit after clamping the word length
    always_comb begin
        if (word_len < 4'd5)
            last_idx = IDX_W'(4);
        else if (32'(word_len) > MAXW)
            last_idx = IDX_W'(MAXW - 1);
        else
            last_idx = IDX_W'(word_len - 4'd1);
    end

    assign par_on = parity_present(parity_mode);

    always_comb begin
        case (parity_mode)
            PAR_ODD:  exp_par = ~^shreg;
            PAR_EVEN: exp_par = ^shreg;
            PAR_HIGH: exp_par = 1'b1;
            default:  exp_par = 1'b0;
        endcase
    end

    assign at_mid  = tick && (samp_cnt == MID);
    assign at_last = tick && (samp_cnt == LAST);
    assign done    = at_mid && ((state == S_STOP1 && !two_stop) || state == S_STOP2);

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:    if (tick && !line) nxt = S_START;
            S_START:   if (at_mid && line) nxt = S_IDLE;
                       else if (at_last) nxt = S_DATA;
            S_DATA:    if (at_last && bit_idx == last_idx)
                           nxt = par_on ? S_PARITY : S_STOP1;
            S_PARITY:  if (at_last) nxt = S_STOP1;
            S_STOP1:   if (two_stop) begin
                           if (at_last) nxt = S_STOP2;
                       end else if (at_mid) begin
                           nxt = line ? S_IDLE : S_RECOVER;
                       end
            S_STOP2:   if (at_mid) nxt = line ? S_IDLE : S_RECOVER;
            S_RECOVER: if (line) nxt = S_IDLE;
            default:   nxt = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          state <= S_IDLE;
        else if (!rx_enable) state <= S_IDLE;
        else                 state <= nxt;
    end

    // Frame datapath: sample counter, bit index, captured bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            samp_cnt <= '0;
            bit_idx  <= '0;
            shreg    <= '0;
            par_bit  <= 1'b0;
            stop_bad <= 1'b0;
        end else if (!rx_enable) begin
            samp_cnt <= '0;
            bit_idx  <= '0;
            stop_bad <= 1'b0;
        end else if (state == S_IDLE && nxt == S_START) begin
            samp_cnt <= SC_W'(1);
            bit_idx  <= '0;
            shreg    <= '0;
            par_bit  <= 1'b0;
            stop_bad <= 1'b0;
        end else if (tick && state != S_IDLE && state != S_RECOVER) begin
            samp_cnt <= (samp_cnt == LAST) ? '0 : samp_cnt + 1'b1;
            if (state == S_DATA && samp_cnt == MID)
                shreg[bit_idx] <= line;
            if (state == S_DATA && samp_cnt == LAST)
                bit_idx <= bit_idx + 1'b1;
            if (state == S_PARITY && samp_cnt == MID)
                par_bit <= line;
            if (state == S_STOP1 && samp_cnt == MID && !line)
                stop_bad <= 1'b1;
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_valid  <= 1'b0;
            word_data   <= '0;
            err_frame   <= 1'b0;
            err_parity  <= 1'b0;
            err_overrun <= 1'b0;
            match_hit   <= 1'b0;
        end else if (!rx_enable) begin
            word_valid  <= 1'b0;
            err_frame   <= 1'b0;
            err_parity  <= 1'b0;
            err_overrun <= 1'b0;
            match_hit   <= 1'b0;
        end else begin
            word_valid  <= done && !fifo_full;
            err_overrun <= done && fifo_full;
            err_frame   <= done && (stop_bad || !line);
            err_parity  <= done && par_on && (par_bit != exp_par);
            match_hit   <= done && (shreg == match_value);
            if (done)
                word_data <= shreg;
        end
    end
endmodule

// File: rtl/srx_checker.sv
module srx_checker (
    input logic clk,
    input logic rst_n,
    input logic rx_enable,
    input logic fifo_full,
    input logic word_valid,
    input logic err_frame,
    input logic err_parity,
    input logic err_overrun,
    input logic match_hit,
    input logic line_break,
    input logic idle_timeout
);
    a_r6_overrun_drops_word: assert property (@(posedge clk) disable iff (!rst_n)
        err_overrun |-> !word_valid);

    a_r6_overrun_only_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        err_overrun |-> $past(fifo_full));

    a_r6_write_only_with_room: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> !$past(fifo_full));

    a_r7_match_at_completion: assert property (@(posedge clk) disable iff (!rst_n)
        match_hit |-> (word_valid || err_overrun));

    a_r5_frame_at_completion: assert property (@(posedge clk) disable iff (!rst_n)
        err_frame |-> (word_valid || err_overrun));

    a_r4_parity_at_completion: assert property (@(posedge clk) disable iff (!rst_n)
        err_parity |-> (word_valid || err_overrun));

    a_r8_break_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        line_break |=> !line_break);

    a_r11_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_enable |=> !(word_valid || err_overrun || line_break || idle_timeout));
endmodule

bind serial_rx_engine srx_checker u_srx_checker (
    .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .fifo_full(fifo_full),
    .word_valid(word_valid), .err_frame(err_frame), .err_parity(err_parity),
    .err_overrun(err_overrun), .match_hit(match_hit), .line_break(line_break),
    .idle_timeout(idle_timeout)
);

// File: tb/tb_serial_rx_engine.sv
`timescale 1ns/1ps
module tb_serial_rx_engine;
    localparam int OVS = 8, MAXW = 9, GF_LEN = 4, PRE_W = 16, TO_W = 6;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic             rst_n, rx_enable, filter_en, two_stop, fifo_full, rxd;
    logic [PRE_W-1:0] prescale;
    logic [3:0]       word_len;
    logic [2:0]       parity_mode;
    logic [TO_W-1:0]  idle_bits;
    logic [MAXW-1:0]  match_value;
    logic             word_valid, err_frame, err_parity, err_overrun, match_hit;
    logic             line_break, idle_timeout;
    logic [MAXW-1:0]  word_data;

    serial_rx_engine #(.OVS(OVS), .MAXW(MAXW), .GF_LEN(GF_LEN), .PRE_W(PRE_W), .TO_W(TO_W)) dut (
        .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .filter_en(filter_en),
        .prescale(prescale), .word_len(word_len), .two_stop(two_stop),
        .parity_mode(parity_mode), .idle_bits(idle_bits), .match_value(match_value),
        .fifo_full(fifo_full), .rxd(rxd), .word_valid(word_valid), .word_data(word_data),
        .err_frame(err_frame), .err_parity(err_parity), .err_overrun(err_overrun),
        .match_hit(match_hit), .line_break(line_break), .idle_timeout(idle_timeout)
    );

    int checks = 0, errors = 0;
    int comp_seen = 0, brk_seen = 0, to_seen = 0;
    int bit_clks = 16;
    bit finished = 1'b0;

    logic [MAXW+4:0] exp_q[$];
    string           tag_q[$];
    logic [MAXW+4:0] got_item, exp_item;
    string           cur_tag;

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp,
                         input string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
        end
    endtask

    function automatic int eff_len(input logic [3:0] wl);
        if (wl < 4'd5) return 5;
        if (int'(wl) > MAXW) return MAXW;
        return int'(wl);
    endfunction

    function automatic bit par_present(input logic [2:0] m);
        return (m == 3'b001) || (m == 3'b010) || (m == 3'b100) || (m == 3'b101);
    endfunction

    function automatic logic par_value(input logic [2:0] m, input logic [MAXW-1:0] d);
        case (m)
            3'b001:  return ~^d;
            3'b010:  return ^d;
            3'b101:  return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic push_exp(input logic [MAXW-1:0] dm, input bit frame_bad,
                            input bit par_bad, input string tag);
        exp_q.push_back({!fifo_full, frame_bad, par_bad, fifo_full, (dm == match_value), dm});
        tag_q.push_back(tag);
    endtask

    task automatic drive_level(input logic v, input int nbits, input bit glitch);
        for (int b = 0; b < nbits; b++) begin
            for (int c = 0; c < bit_clks; c++) begin
                @(negedge clk);
                rxd = v ^ (glitch && (c == 6 || c == 7 || c == 12 || c == 13));
            end
        end
    endtask

    task automatic send_frame(input logic [MAXW-1:0] d, input bit bad_par, input bit bad_stop,
                              input bit glitch, input int idle_after, input bit expect_out,
                              input string tag);
        int              n;
        logic [MAXW-1:0] dm;
        logic            p;
        n  = eff_len(word_len);
        dm = '0;
        for (int i = 0; i < MAXW; i++) if (i < n) dm[i] = d[i];
        p = par_value(parity_mode, dm) ^ bad_par;
        if (expect_out) push_exp(dm, bad_stop, par_present(parity_mode) && bad_par, tag);
        drive_level(1'b0, 1, glitch);
        for (int i = 0; i < n; i++) drive_level(dm[i], 1, glitch);
        if (par_present(parity_mode)) drive_level(p, 1, glitch);
        drive_level(!bad_stop, 1, glitch);
        if (two_stop) drive_level(1'b1, 1, glitch);
        drive_level(1'b1, idle_after, 1'b0);
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (line_break)   brk_seen++;
            if (idle_timeout) to_seen++;
            if (word_valid || err_overrun) begin
                comp_seen++;
                got_item = {word_valid, err_frame, err_parity, err_overrun, match_hit, word_data};
                if (exp_q.size() == 0) begin
                    checks++;
                    errors++;
                    $display("FAIL R2 unexpected completion: actual %h expected none", got_item);
                end else begin
                    exp_item = exp_q.pop_front();
                    cur_tag  = tag_q.pop_front();
                    check(cur_tag, 32'(got_item), 32'(exp_item), "frame result");
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R0 watchdog expired: actual running expected done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    int c0, b0, t0;

    initial begin
        rst_n = 1'b0; rx_enable = 1'b1; filter_en = 1'b0; prescale = 16'd1;
        word_len = 4'd8; two_stop = 1'b0; parity_mode = 3'b000; idle_bits = '0;
        match_value = 9'h0A5; fifo_full = 1'b0; rxd = 1'b1;
        repeat (5) @(negedge clk);
        check("R1", 32'({word_valid, err_frame, err_parity, err_overrun, match_hit,
                         line_break, idle_timeout, word_data}), 0, "outputs in reset");
        rst_n = 1'b1;
        drive_level(1'b1, 4, 1'b0);
        check("R1", 32'(comp_seen), 0, "no word on idle line");
        check("R1", 32'({word_valid, err_frame, err_overrun, line_break, idle_timeout}), 0,
              "outputs idle after reset");

        // R2 basic frames, R7 match
        send_frame(9'h03C, 0, 0, 0, 2, 1, "R2");
        send_frame(9'h0A5, 0, 0, 0, 2, 1, "R7");
        send_frame(9'h0FF, 0, 0, 0, 1, 1, "R2");
        send_frame(9'h001, 0, 0, 0, 2, 1, "R2");
        // R2 word length clamp and zero fill
        word_len = 4'd5;  send_frame(9'h1FF, 0, 0, 0, 2, 1, "R2");
        word_len = 4'd9;  send_frame(9'h155, 0, 0, 0, 2, 1, "R2");
        word_len = 4'd12; send_frame(9'h1AB, 0, 0, 0, 2, 1, "R2");
        word_len = 4'd3;  send_frame(9'h0F6, 0, 0, 0, 2, 1, "R2");
        word_len = 4'd8;
        check("R2", 32'(exp_q.size()), 0, "all basic words seen");

        // R4 parity modes
        parity_mode = 3'b001; send_frame(9'h037, 0, 0, 0, 2, 1, "R4");
                              send_frame(9'h037, 1, 0, 0, 2, 1, "R4");
        parity_mode = 3'b010; send_frame(9'h0C3, 0, 0, 0, 2, 1, "R4");
                              send_frame(9'h0C2, 1, 0, 0, 2, 1, "R4");
        parity_mode = 3'b100; send_frame(9'h011, 1, 0, 0, 2, 1, "R4");
        parity_mode = 3'b101; send_frame(9'h011, 0, 0, 0, 2, 1, "R4");
        parity_mode = 3'b011; send_frame(9'h05A, 0, 0, 0, 2, 1, "R4");
        parity_mode = 3'b000;
        check("R4", 32'(exp_q.size()), 0, "all parity words seen");

        // R5 framing errors, one and two stop bits
        send_frame(9'h066, 0, 1, 0, 2, 1, "R5");
        send_frame(9'h000, 0, 1, 0, 2, 1, "R5");
        two_stop = 1'b1;
        send_frame(9'h09C, 0, 0, 0, 2, 1, "R2");
        send_frame(9'h09C, 0, 1, 0, 2, 1, "R5");
        two_stop = 1'b0;
        send_frame(9'h042, 0, 0, 0, 2, 1, "R5");
        check("R5", 32'(exp_q.size()), 0, "all stop-bit words seen");

        // R6 overrun
        fifo_full = 1'b1; send_frame(9'h0A5, 0, 0, 0, 2, 1, "R6");
        fifo_full = 1'b0; send_frame(9'h07E, 0, 0, 0, 2, 1, "R6");
        check("R6", 32'(exp_q.size()), 0, "overrun words seen");

        // R3 false start then a good frame
        c0 = comp_seen;
        for (int i = 0; i < 4; i++) begin @(negedge clk); rxd = 1'b0; end
        @(negedge clk); rxd = 1'b1;
        drive_level(1'b1, 3, 1'b0);
        check("R3", 32'(comp_seen), 32'(c0), "false start ignored");
        send_frame(9'h0B4, 0, 0, 0, 2, 1, "R3");
        // R3 slower tick
        prescale = 16'd3; bit_clks = 32;
        drive_level(1'b1, 1, 1'b0);
        send_frame(9'h0C9, 0, 0, 0, 2, 1, "R3");
        prescale = 16'd1; bit_clks = 16;
        drive_level(1'b1, 1, 1'b0);
        check("R3", 32'(exp_q.size()), 0, "prescaled word seen");

        // R10 glitch filter
        filter_en = 1'b1;
        drive_level(1'b1, 2, 1'b0);
        send_frame(9'h0A6, 0, 0, 1, 2, 1, "R10");
        send_frame(9'h059, 0, 0, 1, 2, 1, "R10");
        filter_en = 1'b0;
        drive_level(1'b1, 2, 1'b0);
        check("R10", 32'(exp_q.size()), 0, "filtered words seen");

        // R8 break: 11 low bits no pulse, 16 low bits one pulse
        check("R9", 32'(to_seen), 0, "no timeout while disabled");
        b0 = brk_seen;
        push_exp(9'h000, 1, 0, "R8");
        drive_level(1'b0, 11, 1'b0);
        drive_level(1'b1, 3, 1'b0);
        check("R8", 32'(brk_seen), 32'(b0), "11 low bits no break");
        push_exp(9'h000, 1, 0, "R8");
        drive_level(1'b0, 16, 1'b0);
        drive_level(1'b1, 3, 1'b0);
        check("R8", 32'(brk_seen), 32'(b0 + 1), "16 low bits one break");
        check("R8", 32'(exp_q.size()), 0, "break frames seen");

        // R9 idle timeout
        idle_bits = 6'd3;
        t0 = to_seen;
        send_frame(9'h011, 0, 0, 0, 1, 1, "R9");
        check("R9", 32'(to_seen), 32'(t0), "short gap no timeout");
        send_frame(9'h022, 0, 0, 0, 8, 1, "R9");
        check("R9", 32'(to_seen), 32'(t0 + 1), "timeout after idle");
        drive_level(1'b1, 6, 1'b0);
        check("R9", 32'(to_seen), 32'(t0 + 1), "timeout fires once");
        idle_bits = '0;

        // R11 disable
        c0 = comp_seen;
        rx_enable = 1'b0;
        send_frame(9'h0A5, 0, 0, 0, 2, 0, "R11");
        check("R11", 32'(comp_seen), 32'(c0), "no word while disabled");
        rx_enable = 1'b1;
        drive_level(1'b1, 2, 1'b0);
        send_frame(9'h0E1, 0, 0, 0, 2, 1, "R11");
        check("R11", 32'(comp_seen), 32'(c0 + 1), "word after re-enable");
        check("R11", 32'(exp_q.size()), 0, "queue drained");

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule